// File: doc/BRIEF.md
# Eight-line priority interrupt controller

The block gathers eight interrupt request lines and tells a processor when one of them needs service. Software programs it through a byte-wide register port with three addresses: a command address, a data address and a trigger-select address. After reset, a short burst of writes (a start word on the command address followed by two or three words on the data address) sets the vector base, a cascade byte for a neighbouring controller, and a processor-mode bit. Once that burst is over, data-address writes change the mask.

Each line is either edge-sensitive or level-sensitive, chosen per line in the trigger-select register. Pending requests sit in a request register. Unmasked requests are ranked by fixed priority, and line 0 ranks highest. The interrupt output is raised only when the best pending request outranks everything already in service. A one-cycle acknowledge pulse moves the winner into the in-service register and returns a vector byte one cycle later. A command write of 0x20 retires the highest-priority in-service line. If the request has vanished by the time of the acknowledge, the block returns the line-7 vector and marks nothing in service, so software can tell the interrupt was spurious.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask reads 0xFF, the request, in-service and trigger-select registers read 0x00, command-address reads return the request register, `int_out` is low, and `cpu_mode`, `casc_cfg` and the vector base are 0.
- R2: A command write with bit 4 set starts programming, and its bit 0 says whether a mode word follows. The next data writes load the vector base (bits 7:3; bits 2:0 are ignored), then `casc_cfg`, then, if requested, `cpu_mode` from bit 0. Without a mode word, `cpu_mode` is cleared. The mask does not change during this burst.
- R3: Outside the programming burst, a data-address (1) write loads the mask, and a data-address read returns it. A mask bit of 1 stops its line from raising `int_out` or winning an acknowledge.
- R4: The trigger-select register at address 2 is readable and writable. Bit n = 1 makes line n level-sensitive, and bit n = 0 makes it edge-sensitive.
- R5: An edge-sensitive line sets its request bit on a rising edge. The bit stays set after the line drops and is cleared when that line wins an acknowledge.
- R6: A level-sensitive line's request bit follows the line one cycle late and falls when the line falls.
- R7: `int_out` is high exactly when some unmasked request has a lower line index than every in-service bit. Among such requests, the lowest index wins.
- R8: An acknowledge while `int_out` is high sets the winner's in-service bit. In the next cycle `ack_valid` is high and `ack_vector` equals the base (bits 7:3) ORed with the line number.
- R9: An acknowledge while `int_out` is low returns base ORed with 7 and leaves the in-service register unchanged.
- R10: A command write of 0x20 clears only the lowest-index set in-service bit.
- R11: A command write with bits 4:3 = 01 and bit 1 = 1 selects what command-address reads return: bit 0 = 1 selects in-service, and 0 selects request. With bit 1 = 0 the selection is left as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 command, 1 data/mask, 2 trigger select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq_in | input | 8 | Interrupt request lines |
| ack | input | 1 | One-cycle acknowledge pulse |
| int_out | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | High the cycle after an acknowledge |
| ack_vector | output | 8 | Vector byte returned for the acknowledge |
| casc_cfg | output | 8 | Cascade byte from programming |
| cpu_mode | output | 1 | Processor-mode bit from programming |

## Verification
The in-service assertions assume that an acknowledge and a 0x20 command never arrive in the same cycle, and that request lines are low while reset is held. The stimulus keeps both rules: every acknowledge and every command write happens in a separate bus task, and the lines are driven only after reset is released. Between table entries, each line is switched to level mode for a cycle while the line is low. This clears any latched edge requests, so every vector starts from an empty request register.

// File: rtl/irq_ctrl_pkg.sv
// Shared constants and types for the priority interrupt controller.
package irq_ctrl_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CMD  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_TRIG = 2'd2;

    localparam logic [BYTE_W-1:0] CMD_RETIRE = 8'h20;

    typedef enum logic [1:0] {
        PRG_IDLE = 2'd0,
        PRG_BASE = 2'd1,
        PRG_CASC = 2'd2,
        PRG_MODE = 2'd3
    } prg_state_e;
endpackage

// File: rtl/irq_cfg_regs.sv
// Register port: programming sequencer, mask, trigger select and readback select.
// Assumes a single write per cycle and N_LINES <= BYTE_W.
module irq_cfg_regs
    import irq_ctrl_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IDX_W = $clog2(N_LINES),
    localparam int BASE_W = BYTE_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [N_LINES-1:0] mask,
    output logic [N_LINES-1:0] trig,
    output logic [BASE_W-1:0]  base_hi,
    output logic [BYTE_W-1:0]  casc,
    output logic               mode,
    output logic               sel_isr,
    output logic               retire
);
    prg_state_e state;
    logic       want_mode;
    logic       cmd_wr;
    logic       data_wr;

    // Decode the write strobes per address.
    always_comb begin
        cmd_wr  = wr && (addr == ADDR_CMD);
        data_wr = wr && (addr == ADDR_DATA);
        retire  = cmd_wr && (wdata == CMD_RETIRE);
    end

    // Programming sequencer and the registers it loads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PRG_IDLE;
            want_mode <= 1'b0;
            base_hi   <= '0;
            casc      <= '0;
            mode      <= 1'b0;
            mask      <= '1;
        end else if (cmd_wr && wdata[4]) begin
            state     <= PRG_BASE;
            want_mode <= wdata[0];
        end else if (data_wr) begin
            unique case (state)
                PRG_BASE: begin
                    base_hi <= wdata[BYTE_W-1:IDX_W];
                    state   <= PRG_CASC;
                end
                PRG_CASC: begin
                    casc <= wdata;
                    if (want_mode) begin
                        state <= PRG_MODE;
                    end else begin
                        mode  <= 1'b0;
                        state <= PRG_IDLE;
                    end
                end
                PRG_MODE: begin
                    mode  <= wdata[0];
                    state <= PRG_IDLE;
                end
                default: mask <= wdata[N_LINES-1:0];
            endcase
        end
    end

    // Readback selection for command-address reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_isr <= 1'b0;
        end else if (cmd_wr && (wdata[4:3] == 2'b01) && wdata[1]) begin
            sel_isr <= wdata[0];
        end
    end

    // Per-line trigger select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig <= '0;
        end else if (wr && (addr == ADDR_TRIG)) begin
            trig <= wdata[N_LINES-1:0];
        end
    end

    // R2: the first data write after a start word loads the base.
    a_r2_base_load: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state == PRG_BASE && !cmd_wr) |=> (base_hi == $past(wdata[BYTE_W-1:IDX_W])));

    // R2: the mask does not change while a programming burst is in progress.
    a_r2_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PRG_IDLE) |=> (mask == $past(mask)));

    // R3: once programming is idle, a data write loads the mask.
    a_r3_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && state == PRG_IDLE) |=> (mask == $past(wdata[N_LINES-1:0])));
endmodule

// File: rtl/irq_req_capture.sv
// Request register: edge-sensitive lines latch on a rising edge until cleared,
// level-sensitive lines follow the input. Assumes lines are low during reset.
module irq_req_capture #(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines,
    input  logic [N_LINES-1:0] trig,
    input  logic [N_LINES-1:0] clr,
    output logic [N_LINES-1:0] irr
);
    logic [N_LINES-1:0] prev;

    // Previous line sample for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lines;
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        // Update one request bit according to its trigger mode.
        always_ff @(posedge clk) begin
            if (!rst_n)       irr[g] <= 1'b0;
            else if (trig[g]) irr[g] <= lines[g];
            else              irr[g] <= (irr[g] | (lines[g] & ~prev[g])) & ~clr[g];
        end
    end

    // R5: an edge-mode request stays latched until its line is acknowledged.
    a_r5_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(irr & ~trig & ~clr)) & ~trig & ~irr) == '0));

    // R6: a level-mode request bit matches the line of the previous cycle.
    a_r6_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((irr ^ $past(lines)) & trig & $past(trig)) == '0));
endmodule

// File: rtl/irq_resolver.sv
// Fixed-priority resolver, in-service register, retire handling and vector
// return. Line 0 ranks highest. Assumes ack and retire are not simultaneous.
module irq_resolver
    import irq_ctrl_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IDX_W = $clog2(N_LINES),
    localparam int BASE_W = BYTE_W - IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irr,
    input  logic [N_LINES-1:0] mask,
    input  logic [BASE_W-1:0]  base_hi,
    input  logic               ack,
    input  logic               retire,
    output logic               int_req,
    output logic [N_LINES-1:0] isr,
    output logic [N_LINES-1:0] grant,
    output logic               vec_valid,
    output logic [BYTE_W-1:0]  vec
);
    logic [N_LINES-1:0] elig;
    logic [IDX_W-1:0]   win_idx;
    logic               win_any;
    logic [IDX_W-1:0]   top_idx;
    logic               top_any;
    logic [N_LINES-1:0] retire_bit;

    // Lowest-index eligible request and lowest-index in-service bit.
    always_comb begin
        elig    = irr & ~mask;
        win_idx = '0;
        win_any = 1'b0;
        top_idx = '0;
        top_any = 1'b0;
        for (int i = N_LINES - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_idx = IDX_W'(i);
                win_any = 1'b1;
            end
            if (isr[i]) begin
                top_idx = IDX_W'(i);
                top_any = 1'b1;
            end
        end
    end

    // Request decision, grant and retire one-hots.
    always_comb begin
        int_req    = win_any && (!top_any || (win_idx < top_idx));
        grant      = (ack && int_req) ? (N_LINES'(1) << win_idx) : '0;
        retire_bit = (retire && top_any) ? (N_LINES'(1) << top_idx) : '0;
    end

    // In-service register update.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~retire_bit) | grant;
    end

    // Vector byte returned one cycle after the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec       <= '0;
        end else begin
            vec_valid <= ack;
            if (ack) vec <= {base_hi, (int_req ? win_idx : IDX_W'(N_LINES - 1))};
        end
    end

    // R8: a real acknowledge adds exactly one in-service bit.
    a_r8_ack_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_req && !retire) |=> ($countones(isr) == $countones($past(isr)) + 1));

    // R9: a spurious acknowledge leaves the in-service register alone.
    a_r9_spurious_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_req && !retire) |=> (isr == $past(isr)));

    // R9: a spurious acknowledge returns the last line's vector.
    a_r9_spurious_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_req) |=> (vec[IDX_W-1:0] == IDX_W'(N_LINES - 1)));

    // R10: a retire removes exactly one in-service bit when any is set.
    a_r10_retire_one: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !ack && isr != '0) |=> ($countones(isr) == $countones($past(isr)) - 1));

    // R7: at most one line is granted per acknowledge.
    a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the eight-line priority interrupt controller: register port,
// request capture, resolver and read multiplexer.
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int IDX_W = $clog2(N_LINES),
    localparam int BASE_W = BYTE_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [7:0]        irq_in,
    input  logic              ack,
    output logic              int_out,
    output logic              ack_valid,
    output logic [7:0]        ack_vector,
    output logic [7:0]        casc_cfg,
    output logic              cpu_mode
);
    logic [N_LINES-1:0] mask;
    logic [N_LINES-1:0] trig;
    logic [BASE_W-1:0]  base_hi;
    logic               sel_isr;
    logic               retire;
    logic [N_LINES-1:0] irr;
    logic [N_LINES-1:0] isr;
    logic [N_LINES-1:0] grant;

    irq_cfg_regs #(.N_LINES(N_LINES)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .mask(mask), .trig(trig), .base_hi(base_hi), .casc(casc_cfg),
        .mode(cpu_mode), .sel_isr(sel_isr), .retire(retire)
    );

    irq_req_capture #(.N_LINES(N_LINES)) u_cap (
        .clk(clk), .rst_n(rst_n), .lines(irq_in[N_LINES-1:0]), .trig(trig),
        .clr(grant), .irr(irr)
    );

    irq_resolver #(.N_LINES(N_LINES)) u_res (
        .clk(clk), .rst_n(rst_n), .irr(irr), .mask(mask), .base_hi(base_hi),
        .ack(ack), .retire(retire), .int_req(int_out), .isr(isr), .grant(grant),
        .vec_valid(ack_valid), .vec(ack_vector)
    );

    // Read multiplexer for the register port.
    always_comb begin
        unique case (reg_addr)
            ADDR_CMD:  reg_rdata = BYTE_W'(sel_isr ? isr : irr);
            ADDR_DATA: reg_rdata = BYTE_W'(mask);
            ADDR_TRIG: reg_rdata = BYTE_W'(trig);
            default:   reg_rdata = '0;
        endcase
    end

    // R3: a masked request never raises the interrupt output on its own.
    a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (((irr & ~mask) == '0)) |-> !int_out);
endmodule

// File: tb/sim_irq_prio_ctrl.sv
// Self-checking bench for irq_prio_ctrl: a vector table, then directed tests.
module sim_irq_prio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 6;
    // Entry: {trigger select, mask, lines, int expected, winning line}
    localparam logic [27:0] VEC [0:N_VEC-1] = '{
        {8'h00, 8'h00, 8'h90, 1'b1, 3'd4},
        {8'h00, 8'h10, 8'h90, 1'b1, 3'd7},
        {8'hFF, 8'h00, 8'h06, 1'b1, 3'd1},
        {8'h00, 8'hFF, 8'h01, 1'b0, 3'd0},
        {8'h0F, 8'h01, 8'h03, 1'b1, 3'd1},
        {8'h00, 8'h00, 8'h00, 1'b0, 3'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] irq_in = 8'h00;
    logic       ack = 1'b0;
    logic       int_out;
    logic       ack_valid;
    logic [7:0] ack_vector;
    logic [7:0] casc_cfg;
    logic       cpu_mode;
    int checks = 0;
    int errors = 0;

    irq_prio_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_in(irq_in), .ack(ack),
        .int_out(int_out), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .casc_cfg(casc_cfg), .cpu_mode(cpu_mode)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic drive(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic pulse_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic flush();
        irq_in = 8'h00;
        wr(2'd2, 8'hFF);
        wr(2'd2, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [27:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, d); chk("R1 mask", d, 8'hFF);
        rd(2'd0, d); chk("R1 irr", d, 8'h00);
        rd(2'd2, d); chk("R1 trig", d, 8'h00);
        chk("R1 int_out", {7'd0, int_out}, 8'h00);
        chk("R1 mode/casc", {casc_cfg[6:0], cpu_mode}, 8'h00);
        wr(2'd0, 8'h0B); rd(2'd0, d); chk("R1 isr", d, 8'h00);
        wr(2'd0, 8'h0A);

        // R2 programming without a mode word
        wr(2'd0, 8'h10);
        wr(2'd1, 8'h4B);
        rd(2'd1, d); chk("R2 mask frozen", d, 8'hFF);
        wr(2'd1, 8'h02);
        chk("R2 casc", casc_cfg, 8'h02);
        chk("R2 mode cleared", {7'd0, cpu_mode}, 8'h00);
        wr(2'd1, 8'h00);
        rd(2'd1, d); chk("R3 mask load", d, 8'h00);
        drive(8'h02); drive(8'h00);
        pulse_ack();
        chk("R2 base low bits ignored", ack_vector, 8'h49);
        wr(2'd0, 8'h20);

        // R2 programming with a mode word
        wr(2'd0, 8'h11);
        wr(2'd1, 8'h20);
        wr(2'd1, 8'h04);
        wr(2'd1, 8'h01);
        chk("R2 casc", casc_cfg, 8'h04);
        chk("R2 mode", {7'd0, cpu_mode}, 8'h01);
        rd(2'd1, d); chk("R2 mask after burst", d, 8'h00);

        // R4 trigger register
        wr(2'd2, 8'hA5); rd(2'd2, d); chk("R4 trig rw", d, 8'hA5);
        wr(2'd2, 8'h00);

        // Vector table: R3 R4 R7 R8 R10
        for (int k = 0; k < N_VEC; k++) begin
            e = VEC[k];
            wr(2'd2, e[27:20]);
            wr(2'd1, e[19:12]);
            drive(e[11:4]);
            chk($sformatf("R7 table %0d int_out", k), {7'd0, int_out}, {7'd0, e[3]});
            if (e[3]) begin
                pulse_ack();
                chk($sformatf("R8 table %0d valid", k), {7'd0, ack_valid}, 8'h01);
                chk($sformatf("R8 table %0d vector", k), ack_vector, {5'b00100, e[2:0]});
                wr(2'd0, 8'h0B);
                rd(2'd0, d); chk($sformatf("R8 table %0d isr", k), d, 8'h01 << e[2:0]);
                wr(2'd0, 8'h20);
                rd(2'd0, d); chk($sformatf("R10 table %0d isr", k), d, 8'h00);
                wr(2'd0, 8'h0A);
            end
            flush();
        end
        wr(2'd1, 8'h00);

        // R5 edge latch survives the line dropping, cleared by acknowledge
        drive(8'h08); drive(8'h00);
        rd(2'd0, d); chk("R5 edge held", d, 8'h08);
        pulse_ack();
        chk("R5 vector", ack_vector, 8'h23);
        rd(2'd0, d); chk("R5 cleared by ack", d, 8'h00);
        wr(2'd0, 8'h20);

        // R6 level follows the line
        wr(2'd2, 8'h40);
        drive(8'h40);
        rd(2'd0, d); chk("R6 level high", d, 8'h40);
        drive(8'h00);
        rd(2'd0, d); chk("R6 level low", d, 8'h00);
        chk("R6 int low", {7'd0, int_out}, 8'h00);
        wr(2'd2, 8'h00);

        // R7 nesting against in-service, R10 retire order, R11 readback select
        drive(8'h20);
        pulse_ack();
        chk("R8 vector line5", ack_vector, 8'h25);
        drive(8'h60);
        chk("R7 lower blocked", {7'd0, int_out}, 8'h00);
        drive(8'h64);
        chk("R7 higher passes", {7'd0, int_out}, 8'h01);
        pulse_ack();
        chk("R7 vector line2", ack_vector, 8'h22);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); chk("R11 isr select", d, 8'h24);
        wr(2'd0, 8'h08);
        rd(2'd0, d); chk("R11 bit1 clear ignored", d, 8'h24);
        wr(2'd0, 8'h20);
        rd(2'd0, d); chk("R10 retire lowest", d, 8'h20);
        wr(2'd0, 8'h0A);
        rd(2'd0, d); chk("R11 irr select", d, 8'h40);
        wr(2'd0, 8'h20);
        chk("R7 pending after retire", {7'd0, int_out}, 8'h01);
        flush();

        // R9 spurious acknowledge
        wr(2'd2, 8'h80);
        drive(8'h80);
        chk("R9 int before drop", {7'd0, int_out}, 8'h01);
        drive(8'h00);
        chk("R9 int after drop", {7'd0, int_out}, 8'h00);
        pulse_ack();
        chk("R9 vector", ack_vector, 8'h27);
        wr(2'd0, 8'h0B);
        rd(2'd0, d); chk("R9 isr untouched", d, 8'h00);
        wr(2'd0, 8'h0A);
        wr(2'd2, 8'h00);

        // R3 masked edge request stays invisible until unmasked
        wr(2'd1, 8'h02);
        drive(8'h02);
        chk("R3 masked", {7'd0, int_out}, 8'h00);
        wr(2'd1, 8'h00);
        chk("R3 unmasked", {7'd0, int_out}, 8'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule